// File: doc/BRIEF.md
# I2C Wiper Position Register Slave

This block is the register side of a 128-step digital resistor. A two-wire bus master reaches two 7-bit registers through it. The first is a volatile position register that drives the wiper output. The second is a retained position register that models non-volatile storage. A one-bit select register at address 02h decides which of the two is reached through address 00h.

When reset is released, the retained value is recalled into the position register. A write to the retained register loads the wiper as well. It then starts a store period of fixed length. For that whole period the bus is ignored, SDA is released and `busy_o` is high.

SCL and SDA are oversampled in the system clock. Bus events are taken from the synchronized levels: START, STOP and the rising and falling edges of SCL. The slave drives SDA in open-drain style through `sda_oe_o`. A high on `sda_oe_o` pulls the line low.

Top module: `i2c_wiper_ctrl`

## Requirements
- R1: Both position registers keep only the 7 low bits of a written byte. Bit 7 of a written data byte is dropped. Any read of them returns bit 7 as 0.
- R2: After reset, the retained register holds `NV_INIT_POS` and the select register is 0. On the first clock after reset release, the retained value is copied into the position register, so `wiper_o` equals `NV_INIT_POS`.
- R3: The sequence START, device address with R/W=0, register 00h, data, STOP writes the position register when select is 0. The write takes effect on the STOP.
- R4: The slave pulls SDA low in the ninth clock of the device address, register and data bytes of a valid write. `sda_oe_o` changes only while SCL is low.
- R5: A read is START, device address with R/W=0, a register byte, repeated START, device address with R/W=1. The slave then shifts out the addressed register, MSB first.
- R6: A device address other than `DEV_ADDR` gets no acknowledge. The slave then ignores the bus until the next START.
- R7: A register byte other than 00h or 02h is acknowledged, but the data byte that follows is not. No register changes.
- R8: Bit 0 of register 02h selects the target of address 00h: 1 is the retained register and 0 is the position register. A read of 02h returns the select value in bit 0.
- R9: Reading the retained register leaves `wiper_o` unchanged. `wiper_o` is stable throughout a store period.
- R10: A completed write to the retained register raises `busy_o` for exactly `STORE_CYCLES` clocks, within 4 clocks of the STOP.
- R11: After a retained-register write, the position register and the retained register hold the same value.
- R12: While `busy_o` is high, `sda_oe_o` stays low and all bus traffic is ignored. A device address sent during the store gets no acknowledge, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when high |
| wiper_o | output | 7 | Current wiper position |
| busy_o | output | 1 | Store period in progress |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except for START and STOP. They also assume that SCL stays low for more than the synchronizer delay of three clocks, so the slave's acknowledge and data edges fall inside the low phase. The bench drives each bus phase for eight clocks and keeps SCL high across every START and STOP. The bus traffic it sends during a store is complete, well-formed framing, so nothing is ignored for being malformed rather than for being busy.

// File: rtl/i2c_wiper_pkg.sv
`timescale 1ns/1ps
package i2c_wiper_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_TX,
    ST_HOLD
  } bus_state_e;

  localparam logic [7:0] REG_POS = 8'h00;
  localparam logic [7:0] REG_SEL = 8'h02;

  function automatic logic reg_known(input logic [7:0] a);
    return (a == REG_POS) || (a == REG_SEL);
  endfunction

endpackage

// File: rtl/i2c_wiper_sync.sv
`timescale 1ns/1ps
module i2c_wiper_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s      = scl_p[STAGES-1];
  assign sda_s      = sda_p[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_wiper_store_timer.sv
`timescale 1ns/1ps
module i2c_wiper_store_timer #(
  parameter int CYCLES = 1250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (start_i && cnt_q == '0)    cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)               cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/i2c_wiper_regs.sv
`timescale 1ns/1ps
module i2c_wiper_regs
  import i2c_wiper_pkg::*;
#(
  parameter int              POS_W       = 7,
  parameter logic [POS_W-1:0] NV_INIT_POS = 7'h40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       wr_addr_i,
  input  logic [POS_W-1:0] wr_data_i,
  input  logic [7:0]       rd_addr_i,
  output logic [7:0]       rd_data_o,
  output logic [POS_W-1:0] wiper_o,
  output logic             store_o
);
  logic [POS_W-1:0] pos_q, nv_q;
  logic             sel_q, recall_q;

  assign store_o = wr_i && (wr_addr_i == REG_POS) && sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      nv_q     <= NV_INIT_POS;
      sel_q    <= 1'b0;
      recall_q <= 1'b1;
    end else begin
      recall_q <= 1'b0;
      if (recall_q) pos_q <= nv_q;
      if (wr_i) begin
        if (wr_addr_i == REG_POS) begin
          pos_q <= wr_data_i;
          if (sel_q) nv_q <= wr_data_i;
        end else if (wr_addr_i == REG_SEL) begin
          sel_q <= wr_data_i[0];
        end
      end
    end
  end

  always_comb begin
    if (rd_addr_i == REG_POS)      rd_data_o = 8'(sel_q ? nv_q : pos_q);
    else if (rd_addr_i == REG_SEL) rd_data_o = {7'b0, sel_q};
    else                           rd_data_o = 8'h00;
  end

  assign wiper_o = pos_q;
endmodule

// File: rtl/i2c_wiper_ctrl.sv
`timescale 1ns/1ps
module i2c_wiper_ctrl
  import i2c_wiper_pkg::*;
#(
  parameter logic [6:0]       DEV_ADDR     = 7'h28,
  parameter int               POS_W        = 7,
  parameter logic [POS_W-1:0] NV_INIT_POS  = 7'h40,
  parameter int               STORE_CYCLES = 1250000,
  parameter int               SYNC_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic [POS_W-1:0] wiper_o,
  output logic             busy_o
);
  localparam int BITS_W = 4;

  logic sda_s, scl_rise, scl_fall, ev_start, ev_stop;
  logic rise, fall, start, stop;

  bus_state_e         state_q;
  logic [BITS_W-1:0]  bit_cnt_q;
  logic [7:0]         sh_q, ptr_q, rd_data;
  logic [6:0]         tx_q;
  logic               rw_q, oe_q, pend_q, store;
  logic [POS_W-1:0]   pend_data_q;
  logic               commit;

  i2c_wiper_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(ev_start), .stop_o(ev_stop)
  );

  // bus events are dropped while a store runs
  assign rise   = scl_rise & ~busy_o;
  assign fall   = scl_fall & ~busy_o;
  assign start  = ev_start & ~busy_o;
  assign stop   = ev_stop  & ~busy_o;
  assign commit = stop & pend_q;

  i2c_wiper_regs #(.POS_W(POS_W), .NV_INIT_POS(NV_INIT_POS)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(commit), .wr_addr_i(ptr_q), .wr_data_i(pend_data_q),
    .rd_addr_i(ptr_q), .rd_data_o(rd_data),
    .wiper_o(wiper_o), .store_o(store)
  );

  i2c_wiper_store_timer #(.CYCLES(STORE_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(store), .busy_o(busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      sh_q        <= '0;
      ptr_q       <= '0;
      tx_q        <= '0;
      rw_q        <= 1'b0;
      oe_q        <= 1'b0;
      pend_q      <= 1'b0;
      pend_data_q <= '0;
    end else if (busy_o) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else if (start) begin
      state_q   <= ST_DEV;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
      pend_q    <= 1'b0;
    end else if (stop) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_REG, ST_DATA: begin
          if (rise) begin
            sh_q      <= {sh_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + BITS_W'(1);
          end else if (fall && bit_cnt_q == BITS_W'(8)) begin
            bit_cnt_q <= '0;
            if (state_q == ST_DEV) begin
              rw_q    <= sh_q[0];
              oe_q    <= (sh_q[7:1] == DEV_ADDR);
              state_q <= (sh_q[7:1] == DEV_ADDR) ? ST_DEV_ACK : ST_IDLE;
            end else if (state_q == ST_REG) begin
              ptr_q   <= sh_q;
              oe_q    <= 1'b1;
              state_q <= ST_REG_ACK;
            end else begin
              oe_q    <= reg_known(ptr_q);
              state_q <= reg_known(ptr_q) ? ST_DATA_ACK : ST_IDLE;
              if (reg_known(ptr_q)) begin
                pend_q      <= 1'b1;
                pend_data_q <= sh_q[POS_W-1:0];
              end
            end
          end
        end
        ST_DEV_ACK: if (fall) begin
          if (rw_q) begin
            tx_q    <= rd_data[6:0];
            oe_q    <= ~rd_data[7];
            state_q <= ST_TX;
          end else begin
            oe_q    <= 1'b0;
            state_q <= ST_REG;
          end
        end
        ST_REG_ACK: if (fall) begin
          oe_q    <= 1'b0;
          state_q <= ST_DATA;
        end
        ST_DATA_ACK: if (fall) begin
          oe_q    <= 1'b0;
          state_q <= ST_HOLD;
        end
        ST_TX: if (fall) begin
          if (bit_cnt_q == BITS_W'(7)) begin
            oe_q    <= 1'b0;
            state_q <= ST_HOLD;
          end else begin
            oe_q      <= ~tx_q[6];
            tx_q      <= {tx_q[5:0], 1'b0};
            bit_cnt_q <= bit_cnt_q + BITS_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_wiper_ctrl_chk.sv
`timescale 1ns/1ps
module i2c_wiper_ctrl_chk #(
  parameter int         POS_W        = 7,
  parameter logic [POS_W-1:0] NV_INIT_POS = 7'h40,
  parameter int         STORE_CYCLES = 1250000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic [POS_W-1:0] wiper_o,
  input logic             busy_o
);
  int   busy_cnt_q;
  logic first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_cnt_q <= 0;
      first_q    <= 1'b1;
    end else begin
      busy_cnt_q <= busy_o ? busy_cnt_q + 1 : 0;
      first_q    <= 1'b0;
    end
  end

  a_r2_recall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_q |=> (wiper_o == NV_INIT_POS));

  a_r4_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  a_r9_wiper_held_in_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(wiper_o));

  a_r10_store_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_cnt_q == STORE_CYCLES));

  a_r12_released_in_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_oe_o);
endmodule

bind i2c_wiper_ctrl i2c_wiper_ctrl_chk #(
  .POS_W(POS_W), .NV_INIT_POS(NV_INIT_POS), .STORE_CYCLES(STORE_CYCLES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i),
  .sda_oe_o(sda_oe_o), .wiper_o(wiper_o), .busy_o(busy_o)
);

// File: tb/i2c_wiper_ctrl_bench.sv
`timescale 1ns/1ps
module i2c_wiper_ctrl_bench;
  localparam int         H     = 8;
  localparam int         STORE = 400;
  localparam logic [6:0] DEV   = 7'h2C;
  localparam logic [6:0] NV    = 7'h40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_oe;
  logic [6:0] wiper;
  logic       busy;

  int   checks = 0;
  int   errors = 0;
  bit   cmp_en = 1'b0;
  bit   done = 1'b0;
  logic [6:0] exp_wiper = NV;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_wiper_ctrl #(
    .DEV_ADDR(DEV), .NV_INIT_POS(NV), .STORE_CYCLES(STORE)
  ) u_i2c_wiper_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .wiper_o(wiper), .busy_o(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (cmp_en && rst_n && !done) begin
      chk("R3 wiper vs model", int'(wiper), int'(exp_wiper));
      chk("R12 sda released when idle", int'(sda_oe), 0);
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(H);
    scl = 1'b1;   wait_clk(H);
    sda_m = 1'b0; wait_clk(H);
    scl = 1'b0;   wait_clk(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(H);
    scl = 1'b1;   wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clk(H);
      scl = 1'b1;   wait_clk(H);
      scl = 1'b0;   wait_clk(H);
    end
    sda_m = 1'b1; wait_clk(H);
    scl = 1'b1;   wait_clk(H / 2);
    ack = (sda_line == 1'b0);
    wait_clk(H / 2);
    scl = 1'b0;   wait_clk(H);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    b = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wait_clk(H);
      scl = 1'b1; wait_clk(H / 2);
      b = {b[6:0], sda_line};
      wait_clk(H / 2);
      scl = 1'b0;
    end
    wait_clk(H);
    sda_m = 1'b1; wait_clk(H);  // master NACK
    scl = 1'b1;   wait_clk(H);
    scl = 1'b0;   wait_clk(H);
  endtask

  task automatic wr_txn(input logic [6:0] dev, input logic [7:0] addr,
                        input logic [7:0] data, output bit a0, output bit a1,
                        output bit a2);
    cmp_en = 1'b0;
    bus_start();
    send_byte({dev, 1'b0}, a0);
    send_byte(addr, a1);
    send_byte(data, a2);
    bus_stop();
  endtask

  task automatic rd_txn(input logic [7:0] addr, output logic [7:0] data);
    bit a;
    cmp_en = 1'b0;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(addr, a);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    chk("R5 read address ack", int'(a), 1);
    recv_byte(data);
    bus_stop();
    cmp_en = 1'b1;
  endtask

  initial begin
    bit a0, a1, a2;
    logic [7:0] rd;
    int w, hcyc;

    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    chk("R2 wiper recalled after reset", int'(wiper), int'(NV));
    chk("R2 busy low after reset", int'(busy), 0);
    chk("R4 sda released after reset", int'(sda_oe), 0);
    cmp_en = 1'b1;

    // plain wiper write, bit 7 set in data
    wr_txn(DEV, 8'h00, 8'hD5, a0, a1, a2);
    chk("R4 ack device", int'(a0), 1);
    chk("R4 ack register", int'(a1), 1);
    chk("R4 ack data", int'(a2), 1);
    exp_wiper = 7'h55;
    chk("R1 R3 wiper low 7 bits", int'(wiper), 'h55);
    cmp_en = 1'b1;

    rd_txn(8'h00, rd);
    chk("R5 R1 read wiper bit7 zero", int'(rd), 'h55);

    // wrong device address
    wr_txn(DEV ^ 7'h01, 8'h00, 8'h11, a0, a1, a2);
    chk("R6 no ack on foreign address", int'(a0), 0);
    chk("R6 no ack after mismatch", int'(a1 | a2), 0);
    cmp_en = 1'b1;
    chk("R6 wiper unchanged", int'(wiper), 'h55);

    // unsupported register
    wr_txn(DEV, 8'h05, 8'h33, a0, a1, a2);
    chk("R7 register byte acked", int'(a1), 1);
    chk("R7 data byte not acked", int'(a2), 0);
    cmp_en = 1'b1;
    chk("R7 wiper unchanged", int'(wiper), 'h55);

    // select retained register
    wr_txn(DEV, 8'h02, 8'h01, a0, a1, a2);
    chk("R8 select write acked", int'(a2), 1);
    cmp_en = 1'b1;
    rd_txn(8'h02, rd);
    chk("R8 select reads back", int'(rd), 1);
    rd_txn(8'h00, rd);
    chk("R8 00h maps to retained", int'(rd), int'(NV));
    chk("R9 read of retained keeps wiper", int'(wiper), 'h55);

    // retained write with store timing
    cmp_en = 1'b0;
    bus_start();
    send_byte({DEV, 1'b0}, a0);
    send_byte(8'h00, a1);
    send_byte(8'h93, a2);
    chk("R4 ack retained data", int'(a2), 1);
    sda_m = 1'b0; wait_clk(H);
    scl = 1'b1;   wait_clk(H);
    sda_m = 1'b1;
    w = 0;
    while (!busy && w < 10) begin wait_clk(1); w++; end
    chk("R10 busy rises within 4 clocks", int'(w <= 4), 1);
    hcyc = 0;
    while (busy && hcyc < STORE + 10) begin wait_clk(1); hcyc++; end
    chk("R10 busy length", hcyc, STORE);
    exp_wiper = 7'h13;
    chk("R11 wiper loaded by retained write", int'(wiper), 'h13);
    cmp_en = 1'b1;
    rd_txn(8'h00, rd);
    chk("R11 retained holds value", int'(rd), 'h13);

    wr_txn(DEV, 8'h02, 8'h00, a0, a1, a2);
    cmp_en = 1'b1;
    rd_txn(8'h00, rd);
    chk("R11 wiper equals retained", int'(rd), 'h13);

    // traffic during store is ignored
    wr_txn(DEV, 8'h02, 8'h01, a0, a1, a2);
    wr_txn(DEV, 8'h00, 8'h6A, a0, a1, a2);
    exp_wiper = 7'h6A;
    cmp_en = 1'b1;
    chk("R10 busy after retained write", int'(busy), 1);
    bus_start();
    send_byte({DEV, 1'b0}, a0);
    chk("R12 no ack while busy", int'(a0), 0);
    bus_stop();
    w = 0;
    while (busy && w < STORE + 10) begin wait_clk(1); w++; end
    chk("R12 wiper untouched by ignored traffic", int'(wiper), 'h6A);
    rd_txn(8'h00, rd);
    chk("R11 retained after second store", int'(rd), 'h6A);

    // normal operation resumes
    wr_txn(DEV, 8'h02, 8'h00, a0, a1, a2);
    wr_txn(DEV, 8'h00, 8'h7F, a0, a1, a2);
    chk("R3 write after store acked", int'(a2), 1);
    exp_wiper = 7'h7F;
    cmp_en = 1'b1;
    chk("R3 wiper after store", int'(wiper), 'h7F);
    chk("R3 no store for position write", int'(busy), 0);

    wait_clk(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule